// File: doc/BRIEF.md
# Multi-Source Reset Cause Controller

This block merges every reset request of a small processor core into one system reset output. There are six kinds of request. An external active-low pin is synchronised and filtered against glitches. The other five are a software reset strobe, a watchdog timeout, a hard-trap priority conflict, a mismatch between protected configuration registers and their hardware shadow copies, and an illegal condition: an illegal opcode, a read of an uninitialised working register, or a security fault.

For each request that resets the core, a sticky flag is set in a 16-bit cause register. The flags keep their value through the reset they record, so start-up code can read why the core restarted. Software clears a flag by writing zero to its bit. Only the power-on input clears all flags at once.

A watchdog timeout is handled by power state. In run mode it resets the core. In sleep or idle mode it only produces a wake pulse.

Top module: `rst_cause_ctrl`

## Requirements
- R1: After its two-stage synchroniser, the external pin `ext_rst_n` must be low for at least MIN_PULSE consecutive cycles to assert `sys_rst`. `sys_rst` rises MIN_PULSE+3 clock edges after the first edge that samples the pin low. It stays high while the pin stays low and falls on the 4th edge after the pin returns high. A shorter low pulse has no effect on `sys_rst` or on the flags.
- R2: A one-cycle `sw_rst_req` strobe holds `sys_rst` high for exactly the next cycle and sets flag bit 6.
- R3: With both `core_sleep` and `core_idle` low, a `wdt_timeout` strobe holds `sys_rst` high for the next cycle and sets flag bit 4. It produces no wake pulse.
- R4: With `core_sleep` or `core_idle` high, a `wdt_timeout` strobe gives a one-cycle `wdt_wake` pulse in the next cycle. It causes no reset and sets no flag.
- R5: `trap_take` with a hard level (13, 14 or 15) that is lower than the hard level in service causes a one-cycle reset and sets flag bit 15. An equal or higher hard level, a level below 13, or a trap taken when no hard trap is in service causes no reset. `trap_done` and `sys_rst` both end the level in service.
- R6: If `cfg_live` differs from its shadow copy while `cfg_wr_en` is low, there is a one-cycle reset and flag bit 9 is set. A change made with `cfg_wr_en` high updates the shadow and causes no reset. The shadow also reloads during `sys_rst` and `rst`.
- R7: Each of these causes a one-cycle reset and sets flag bit 14: `opcode_valid` with `opcode[23:16]` equal to 0x3F, `uninit_w_access`, or `security_fault`. Other opcodes cause nothing.
- R8: A `stat_wr_en` write clears each flag whose data bit is 0 and leaves each flag whose data bit is 1. A flag being set in the same cycle wins over a clear. Bits other than 15, 14, 9, 7, 6 and 4 always read 0.
- R9: Flags survive `sys_rst`. While `rst` is high, `stat_q` is 0, `wdt_wake` is 0 and `sys_rst` is 1. `sys_rst` falls one edge after `rst` is released when no source is active.
- R10: Requests in the same cycle set all of their flags. `sys_rst` stays high as long as the filtered external pin is held low, even after shorter requests have ended. The pin sets flag bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| ext_rst_n | input | 1 | External reset pin, asynchronous, active low |
| sw_rst_req | input | 1 | Software reset strobe |
| wdt_timeout | input | 1 | Watchdog timeout strobe |
| core_sleep | input | 1 | Core is in sleep |
| core_idle | input | 1 | Core is idle |
| trap_take | input | 1 | A trap is being entered |
| trap_level | input | 4 | Priority of the trap being entered |
| trap_done | input | 1 | Return from the trap in service |
| cfg_wr_en | input | 1 | Legal update of the protected configuration |
| cfg_live | input | CFG_N*CFG_W | Live protected configuration registers |
| opcode_valid | input | 1 | `opcode` holds a fetched instruction |
| opcode | input | OPC_W | Fetched instruction word |
| uninit_w_access | input | 1 | Uninitialised working-register read |
| security_fault | input | 1 | Security violation |
| stat_wr_en | input | 1 | Cause-register write strobe |
| stat_wr_data | input | 16 | Write data (0 clears a flag) |
| sys_rst | output | 1 | System reset |
| wdt_wake | output | 1 | Wake pulse from a watchdog timeout in low power |
| stat_q | output | 16 | Cause flags |

## Verification
Every strobe-type request is due one clock edge after it is driven: `sys_rst`, `wdt_wake` and the flags are all registered once. The bench drives inputs on the falling edge and checks on the next falling edge, so the result of each random vector is compared in the cycle that follows it. The external pin has a longer path through the synchroniser and the filter counter. For this pin the bench counts falling edges from the moment it drives the pin. It checks that `sys_rst` is still low at MIN_PULSE+2 and high at MIN_PULSE+3, and on release it checks edges 1 to 3 high and edge 4 low.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int STAT_W   = 16;
    localparam int BIT_TRAP = 15;
    localparam int BIT_ILL  = 14;
    localparam int BIT_CFG  = 9;
    localparam int BIT_EXT  = 7;
    localparam int BIT_SW   = 6;
    localparam int BIT_WDT  = 4;

    localparam logic [3:0] HARD_LVL_MIN = 4'd13;

    localparam logic [STAT_W-1:0] FLAG_MASK =
        (16'd1 << BIT_TRAP) | (16'd1 << BIT_ILL) | (16'd1 << BIT_CFG) |
        (16'd1 << BIT_EXT)  | (16'd1 << BIT_SW)  | (16'd1 << BIT_WDT);

    typedef struct packed {
        logic trap;
        logic ill;
        logic cfg;
        logic ext;
        logic sw;
        logic wdt;
    } cause_t;

    function automatic logic [STAT_W-1:0] cause_word(cause_t c);
        logic [STAT_W-1:0] w;
        w           = '0;
        w[BIT_TRAP] = c.trap;
        w[BIT_ILL]  = c.ill;
        w[BIT_CFG]  = c.cfg;
        w[BIT_EXT]  = c.ext;
        w[BIT_SW]   = c.sw;
        w[BIT_WDT]  = c.wdt;
        return w;
    endfunction

    function automatic logic is_hard(logic [3:0] lvl);
        return lvl >= HARD_LVL_MIN;
    endfunction

endpackage

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
    parameter int MIN_PULSE = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic hold
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MIN_PULSE);

    logic             sync1_q, sync2_q;
    logic [CNT_W-1:0] low_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= pin_n;
            sync2_q <= sync1_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            low_cnt_q <= '0;
        else if (sync2_q)
            low_cnt_q <= '0;
        else if (low_cnt_q != CNT_TOP)
            low_cnt_q <= low_cnt_q + 1'b1;
    end

    assign hold = (low_cnt_q == CNT_TOP);

endmodule

// File: rtl/rstc_trap_mon.sv
module rstc_trap_mon
    import rstc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sys_rst,
    input  logic       take,
    input  logic [3:0] level,
    input  logic       done,
    output logic       conflict
);
    logic [3:0] svc_lvl_q;
    logic       svc_hard;

    assign svc_hard = is_hard(svc_lvl_q);
    assign conflict = take && is_hard(level) && svc_hard && (level < svc_lvl_q);

    always_ff @(posedge clk) begin
        if (rst || sys_rst)
            svc_lvl_q <= '0;
        else if (take && is_hard(level) && !(svc_hard && level < svc_lvl_q))
            svc_lvl_q <= level;
        else if (done)
            svc_lvl_q <= '0;
    end

endmodule

// File: rtl/rstc_cfg_guard.sv
module rstc_cfg_guard #(
    parameter int CFG_N = 4,
    parameter int CFG_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sys_rst,
    input  logic                   wr_en,
    input  logic [CFG_N*CFG_W-1:0] live,
    output logic                   mismatch
);
    logic [CFG_N-1:0] diff;
    logic             resync;

    assign resync = rst || sys_rst || wr_en;

    for (genvar g = 0; g < CFG_N; g++) begin : g_shadow
        logic [CFG_W-1:0] shadow_q;
        always_ff @(posedge clk) begin
            if (resync)
                shadow_q <= live[g*CFG_W +: CFG_W];
        end
        assign diff[g] = (live[g*CFG_W +: CFG_W] != shadow_q);
    end

    assign mismatch = !resync && (|diff);

endmodule

// File: rtl/rstc_cause_reg.sv
module rstc_cause_reg
    import rstc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cause_t            set,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] stat
);
    logic [STAT_W-1:0] flags_q, keep;

    assign keep = wr_en ? wr_data : '1;

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else
            flags_q <= ((flags_q & keep) | cause_word(set)) & FLAG_MASK;
    end

    assign stat = flags_q;

endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
    import rstc_pkg::*;
#(
    parameter int          MIN_PULSE   = 8,
    parameter int          CFG_N       = 4,
    parameter int          CFG_W       = 8,
    parameter int          OPC_W       = 24,
    parameter logic [7:0]  ILLEGAL_TAG = 8'h3F
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ext_rst_n,
    input  logic                   sw_rst_req,
    input  logic                   wdt_timeout,
    input  logic                   core_sleep,
    input  logic                   core_idle,
    input  logic                   trap_take,
    input  logic [3:0]             trap_level,
    input  logic                   trap_done,
    input  logic                   cfg_wr_en,
    input  logic [CFG_N*CFG_W-1:0] cfg_live,
    input  logic                   opcode_valid,
    input  logic [OPC_W-1:0]       opcode,
    input  logic                   uninit_w_access,
    input  logic                   security_fault,
    input  logic                   stat_wr_en,
    input  logic [15:0]            stat_wr_data,
    output logic                   sys_rst,
    output logic                   wdt_wake,
    output logic [15:0]            stat_q
);
    logic   ext_hold, trap_conf, cfg_mm, low_power, ill_op;
    logic   sys_rst_q, wdt_wake_q;
    cause_t cause;

    rstc_pin_filter #(.MIN_PULSE(MIN_PULSE)) u_pin (
        .clk   (clk),
        .rst   (rst),
        .pin_n (ext_rst_n),
        .hold  (ext_hold)
    );

    rstc_trap_mon u_trap (
        .clk      (clk),
        .rst      (rst),
        .sys_rst  (sys_rst_q),
        .take     (trap_take),
        .level    (trap_level),
        .done     (trap_done),
        .conflict (trap_conf)
    );

    rstc_cfg_guard #(.CFG_N(CFG_N), .CFG_W(CFG_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .sys_rst  (sys_rst_q),
        .wr_en    (cfg_wr_en),
        .live     (cfg_live),
        .mismatch (cfg_mm)
    );

    assign low_power = core_sleep || core_idle;
    assign ill_op    = opcode_valid && (opcode[OPC_W-1 -: 8] == ILLEGAL_TAG);

    always_comb begin
        cause      = '0;
        cause.trap = trap_conf;
        cause.ill  = ill_op || uninit_w_access || security_fault;
        cause.cfg  = cfg_mm;
        cause.ext  = ext_hold;
        cause.sw   = sw_rst_req;
        cause.wdt  = wdt_timeout && !low_power;
    end

    rstc_cause_reg u_stat (
        .clk     (clk),
        .rst     (rst),
        .set     (cause),
        .wr_en   (stat_wr_en),
        .wr_data (stat_wr_data),
        .stat    (stat_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sys_rst_q  <= 1'b1;
            wdt_wake_q <= 1'b0;
        end else begin
            sys_rst_q  <= |cause;
            wdt_wake_q <= wdt_timeout && low_power;
        end
    end

    assign sys_rst  = sys_rst_q;
    assign wdt_wake = wdt_wake_q;

endmodule

// File: rtl/rstc_checker.sv
module rstc_checker #(
    parameter int OPC_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             sw_rst_req,
    input logic             wdt_timeout,
    input logic             core_sleep,
    input logic             core_idle,
    input logic             opcode_valid,
    input logic [OPC_W-1:0] opcode,
    input logic             cfg_mm,
    input logic             trap_conf,
    input logic             stat_wr_en,
    input logic             sys_rst,
    input logic             wdt_wake,
    input logic [15:0]      stat_q
);
    assert_sw_R2: assert property (@(posedge clk) disable iff (rst)
        sw_rst_req |=> sys_rst && stat_q[6]);

    assert_wdt_run_R3: assert property (@(posedge clk) disable iff (rst)
        (wdt_timeout && !core_sleep && !core_idle) |=> sys_rst && stat_q[4] && !wdt_wake);

    assert_wdt_wake_R4: assert property (@(posedge clk) disable iff (rst)
        (wdt_timeout && (core_sleep || core_idle)) |=> wdt_wake);

    assert_no_stray_wake_R4: assert property (@(posedge clk) disable iff (rst)
        !wdt_timeout |=> !wdt_wake);

    assert_trap_conf_R5: assert property (@(posedge clk) disable iff (rst)
        trap_conf |=> sys_rst && stat_q[15]);

    assert_cfg_mm_R6: assert property (@(posedge clk) disable iff (rst)
        cfg_mm |=> sys_rst && stat_q[9]);

    assert_ill_op_R7: assert property (@(posedge clk) disable iff (rst)
        (opcode_valid && opcode[OPC_W-1 -: 8] == 8'h3F) |=> sys_rst && stat_q[14]);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        !stat_wr_en |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    assert_unused_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (stat_q & 16'h3D2F) == 16'h0000);
endmodule

bind rst_cause_ctrl rstc_checker #(.OPC_W(OPC_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sw_rst_req   (sw_rst_req),
    .wdt_timeout  (wdt_timeout),
    .core_sleep   (core_sleep),
    .core_idle    (core_idle),
    .opcode_valid (opcode_valid),
    .opcode       (opcode),
    .cfg_mm       (cfg_mm),
    .trap_conf    (trap_conf),
    .stat_wr_en   (stat_wr_en),
    .sys_rst      (sys_rst),
    .wdt_wake     (wdt_wake),
    .stat_q       (stat_q)
);

// File: tb/rst_cause_ctrl_tb.sv
module rst_cause_ctrl_tb;
    localparam int MIN_PULSE = 8;
    localparam int CFG_N = 4, CFG_W = 8, OPC_W = 24;

    logic clk = 1'b0, rst = 1'b1;
    logic ext_rst_n = 1'b1, sw_rst_req = 1'b0, wdt_timeout = 1'b0;
    logic core_sleep = 1'b0, core_idle = 1'b0;
    logic trap_take = 1'b0, trap_done = 1'b0;
    logic [3:0] trap_level = '0;
    logic cfg_wr_en = 1'b0;
    logic [CFG_N*CFG_W-1:0] cfg_live = '0;
    logic opcode_valid = 1'b0, uninit_w_access = 1'b0, security_fault = 1'b0;
    logic [OPC_W-1:0] opcode = '0;
    logic stat_wr_en = 1'b0;
    logic [15:0] stat_wr_data = '0;
    logic sys_rst, wdt_wake;
    logic [15:0] stat_q;

    int n_vec = 0, n_bad = 0;
    bit finished = 1'b0;
    logic [15:0] exp_stat = '0;

    always #10 clk = ~clk;

    rst_cause_ctrl #(.MIN_PULSE(MIN_PULSE), .CFG_N(CFG_N), .CFG_W(CFG_W), .OPC_W(OPC_W)) u_dut (
        .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .sw_rst_req(sw_rst_req),
        .wdt_timeout(wdt_timeout), .core_sleep(core_sleep), .core_idle(core_idle),
        .trap_take(trap_take), .trap_level(trap_level), .trap_done(trap_done),
        .cfg_wr_en(cfg_wr_en), .cfg_live(cfg_live), .opcode_valid(opcode_valid),
        .opcode(opcode), .uninit_w_access(uninit_w_access), .security_fault(security_fault),
        .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
        .sys_rst(sys_rst), .wdt_wake(wdt_wake), .stat_q(stat_q)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        sw_rst_req = 0; wdt_timeout = 0; trap_take = 0; trap_done = 0;
        cfg_wr_en = 0; opcode_valid = 0; uninit_w_access = 0; security_fault = 0;
        stat_wr_en = 0;
    endtask

    function automatic logic [15:0] next_stat(logic [15:0] cur, logic wr, logic [15:0] d,
                                              logic [15:0] set);
        return ((cur & (wr ? d : 16'hFFFF)) | set) & 16'hC2D0;
    endfunction

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            report();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) tick();
        // R9: reset state
        chk("R9 sys_rst in rst", {15'd0, sys_rst}, 16'd1);
        chk("R9 wake in rst", {15'd0, wdt_wake}, 16'd0);
        chk("R9 stat in rst", stat_q, 16'd0);
        rst = 0;
        tick();
        chk("R9 sys_rst release", {15'd0, sys_rst}, 16'd0);

        // random strobes: R2 R3 R4 R7 R8
        for (int i = 0; i < 600; i++) begin
            logic [15:0] set;
            logic er;
            sw_rst_req      = ($urandom % 6) == 0;
            wdt_timeout     = ($urandom % 5) == 0;
            core_sleep      = ($urandom % 3) == 0;
            core_idle       = ($urandom % 3) == 0;
            uninit_w_access = ($urandom % 12) == 0;
            security_fault  = ($urandom % 12) == 0;
            opcode_valid    = ($urandom % 2) == 0;
            opcode          = OPC_W'($urandom);
            if (($urandom % 4) == 0) opcode[23:16] = 8'h3F;
            else if (opcode[23:16] == 8'h3F) opcode[23:16] = 8'h3E;
            stat_wr_en      = ($urandom % 4) == 0;
            stat_wr_data    = 16'($urandom);
            set = '0;
            set[6]  = sw_rst_req;
            set[4]  = wdt_timeout && !core_sleep && !core_idle;
            set[14] = (opcode_valid && opcode[23:16] == 8'h3F) || uninit_w_access || security_fault;
            er = |set;
            exp_stat = next_stat(exp_stat, stat_wr_en, stat_wr_data, set);
            begin
                logic ew;
                ew = wdt_timeout && (core_sleep || core_idle);
                tick();
                chk("R2/R3/R7 sys_rst", {15'd0, sys_rst}, {15'd0, er});
                chk("R4 wdt_wake", {15'd0, wdt_wake}, {15'd0, ew});
                chk("R8 stat", stat_q, exp_stat);
            end
        end
        idle_inputs(); core_sleep = 0; core_idle = 0;
        tick();
        chk("R2 quiet", {15'd0, sys_rst}, 16'd0);

        // clear all, R8
        stat_wr_en = 1; stat_wr_data = 16'h0000; tick(); idle_inputs();
        tick();
        chk("R8 clear all", stat_q, 16'd0);

        // R1 short pulse
        ext_rst_n = 0;
        repeat (MIN_PULSE - 1) tick();
        ext_rst_n = 1;
        for (int k = 0; k < 8; k++) begin
            tick();
            chk("R1 short pulse ignored", {15'd0, sys_rst}, 16'd0);
        end
        chk("R1 short no flag", stat_q, 16'd0);

        // R1 long pulse, R10 mixed
        ext_rst_n = 0;
        repeat (MIN_PULSE + 2) tick();
        chk("R1 not yet", {15'd0, sys_rst}, 16'd0);
        tick();
        chk("R1 asserted", {15'd0, sys_rst}, 16'd1);
        sw_rst_req = 1; wdt_timeout = 1; tick(); idle_inputs();
        chk("R10 held during sw", {15'd0, sys_rst}, 16'd1);
        tick(); tick();
        chk("R10 held after sw", {15'd0, sys_rst}, 16'd1);
        chk("R10 flags", stat_q, 16'h00D0);
        ext_rst_n = 1;
        for (int k = 1; k <= 3; k++) begin
            tick();
            chk("R1 release tail", {15'd0, sys_rst}, 16'd1);
        end
        tick();
        chk("R1 released", {15'd0, sys_rst}, 16'd0);

        // R8 write ones keeps, write zero clears bit 7, set wins clear
        stat_wr_en = 1; stat_wr_data = 16'hFFFF; tick(); idle_inputs();
        chk("R8 ones keep", stat_q, 16'h00D0);
        stat_wr_en = 1; stat_wr_data = 16'hFF7F; tick(); idle_inputs();
        chk("R8 clear bit7", stat_q, 16'h0050);
        stat_wr_en = 1; stat_wr_data = 16'h0000; sw_rst_req = 1; tick(); idle_inputs();
        chk("R8 set beats clear", stat_q, 16'h0040);
        tick();
        chk("R9 flag survives", stat_q, 16'h0040);
        stat_wr_en = 1; stat_wr_data = 16'h0000; tick(); idle_inputs();

        // R5 trap conflicts
        trap_take = 1; trap_level = 4'd15; tick(); idle_inputs();
        chk("R5 first hard trap", {15'd0, sys_rst}, 16'd0);
        trap_take = 1; trap_level = 4'd5; tick(); idle_inputs();
        chk("R5 soft trap no conflict", {15'd0, sys_rst}, 16'd0);
        trap_take = 1; trap_level = 4'd13; tick(); idle_inputs();
        chk("R5 conflict reset", {15'd0, sys_rst}, 16'd1);
        chk("R5 flag", stat_q, 16'h8000);
        tick();
        trap_take = 1; trap_level = 4'd13; tick(); idle_inputs();
        chk("R5 cleared by reset", {15'd0, sys_rst}, 16'd0);
        trap_take = 1; trap_level = 4'd14; tick(); idle_inputs();
        chk("R5 higher ok", {15'd0, sys_rst}, 16'd0);
        trap_take = 1; trap_level = 4'd14; tick(); idle_inputs();
        chk("R5 equal ok", {15'd0, sys_rst}, 16'd0);
        trap_done = 1; tick(); idle_inputs();
        trap_take = 1; trap_level = 4'd13; tick(); idle_inputs();
        chk("R5 after done ok", {15'd0, sys_rst}, 16'd0);
        trap_done = 1; tick(); idle_inputs();

        // R6 configuration shadow
        stat_wr_en = 1; stat_wr_data = 16'h0000; tick(); idle_inputs();
        cfg_wr_en = 1; cfg_live = 32'hA5A5_0F0F; tick(); idle_inputs();
        chk("R6 legal write", {15'd0, sys_rst}, 16'd0);
        tick();
        chk("R6 stable", {15'd0, sys_rst}, 16'd0);
        cfg_live[9] = ~cfg_live[9]; tick();
        chk("R6 mismatch reset", {15'd0, sys_rst}, 16'd1);
        chk("R6 flag", stat_q, 16'h0200);
        tick();
        chk("R6 resynced", {15'd0, sys_rst}, 16'd0);

        // R9 power-on clears
        rst = 1; tick();
        chk("R9 rst clears", stat_q, 16'd0);
        rst = 0; tick();
        chk("R9 out of rst", {15'd0, sys_rst}, 16'd0);

        finished = 1'b1;
        report();
    end
endmodule